// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel. It holds a packed 32-bit timing word for each attached device, four words in the default build of two channels with two devices each. A start pulse launches one access. The access uses the selected device's word and one of two access kinds. Data cycles (PIO or multiword DMA) and task-file register cycles each have their own setup, active and recovery lengths. Every length is coded as its field value plus one clock.

An access runs a setup phase, then an active phase with one strobe low, then a recovery phase, and ends with a one-cycle done pulse. A start that arrives during recovery chains a second cycle onto the burst. That cycle goes straight from recovery into its own active phase and skips the setup phase. The upper four bits of each word hold mode enables (UDMA, DMA, bus mastering in PIO, FIFO). The block only stores them. Loading a PIO word forces the FIFO enable off, and loading a DMA word forces it on.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset, rd_n and wr_n are 1, busy and done are 0, and every stored word equals RESET_WORD (default 0), so cfg_flags reads 0.
- R2: A data access (acc_reg=0) uses setup = bits 24:22, active = bits 8:4 and recovery = bits 3:0, and each phase lasts field+1 clocks. If start is sampled at edge k, the strobe falls at edge k+S+1 and stays low for A+1 cycles. Recovery then lasts R+1 cycles.
- R3: A register access (acc_reg=1) uses setup = bits 27:25, active = bits 17:13 and recovery = bits 12:9, with the same field+1 rule.
- R4: If acc_write=1, wr_n pulses. If acc_write=0, rd_n pulses. The two strobes are never low together, and both are 1 whenever busy is 0.
- R5: busy rises on the edge that samples start and stays high until recovery ends. done is high for exactly one cycle, the cycle after the last recovery cycle.
- R6: A start sampled during recovery chains onto the burst. When recovery ends, the next active phase begins at once, with no setup phase. The done pulse of the earlier cycle coincides with the first active cycle of the next.
- R7: A start sampled during setup or active has no effect. Recovery holds at most one pending start.
- R8: The timing word, the access kind and the direction are captured on the edge that accepts start. A configuration write after that edge does not change the running cycle. The next access uses the new word.
- R9: An access uses stored word index dev_sel + DEV_PER_CH × ch_sel, which is dev + 2 × channel in the default build.
- R10: A configuration write stores cfg_word with bit 31 (FIFO enable) replaced by cfg_dma. cfg_flags shows bits 31:28 of the word at cfg_idx: bit 3 is FIFO enable, bit 2 is bus mastering in PIO, bit 1 is DMA enable and bit 0 is UDMA enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the configuration word at cfg_idx |
| cfg_idx | input | IDX_W (2) | Device word index for writes and flag readout |
| cfg_word | input | 32 | Timing and mode word to store |
| cfg_dma | input | 1 | 1 = DMA word (FIFO forced on), 0 = PIO word (FIFO forced off) |
| cfg_flags | output | 4 | Bits 31:28 of the stored word at cfg_idx |
| start | input | 1 | One-cycle pulse that requests an access |
| ch_sel | input | CH_W (1) | Channel of the access |
| dev_sel | input | DEV_W (1) | Device within the channel |
| acc_reg | input | 1 | 1 = task-file register access, 0 = data access |
| acc_write | input | 1 | 1 = write (wr_n), 0 = read (rd_n) |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | An access or a burst is in progress |
| done | output | 1 | One-cycle pulse after each cycle's recovery |

## Verification
Every result is timed from the edge that samples start. The strobe falls S+2 falling-edge samples after the sample that showed start, stays low for A+1 samples, and done appears R+2 samples after the last low sample. A chained cycle falls R+2 samples after the previous strobe ends. The driver computes these counts from its own model of the stored words and queues them. The monitor samples at falling edges and measures each count against a reference that resets on an idle start and on every strobe release, so each value is compared in the exact cycle it falls due. Flag readout is checked on the first falling edge after the write edge, and ignored starts are confirmed by an empty queue and a matching done count once the channel is idle.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

   localparam int TW_W   = 32;
   localparam int SET_W  = 3;
   localparam int ACT_W  = 5;
   localparam int REC_W  = 4;

   // field positions inside a timing word
   localparam int D_REC_LSB = 0;
   localparam int D_ACT_LSB = 4;
   localparam int R_REC_LSB = 9;
   localparam int R_ACT_LSB = 13;
   localparam int D_SET_LSB = 22;
   localparam int R_SET_LSB = 25;
   localparam int FLAG_LSB  = 28;
   localparam int FLAG_W    = 4;
   localparam int FIFO_BIT  = 31;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [SET_W-1:0] setup;
      logic [ACT_W-1:0] active;
      logic [REC_W-1:0] recov;
   } phase_tm_t;

endpackage

// File: rtl/ata_tw_bank.sv
module ata_tw_bank
   import ata_strobe_pkg::*;
#(
   parameter int          NUM_WORDS  = 4,
   parameter int          IDX_W      = 2,
   parameter logic [31:0] RESET_WORD = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TW_W-1:0]   wr_word,
   input  logic              wr_dma,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [TW_W-1:0]   rd_word_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [FLAG_W-1:0] rd_flags_b
);

   logic [TW_W-1:0] mem [NUM_WORDS];
   logic [TW_W-1:0] wr_val;

   if (NUM_WORDS != (1 << IDX_W)) begin : g_bad_depth
      $error("ata_tw_bank: NUM_WORDS must equal 2**IDX_W");
   end

   // FIFO enable follows the kind of word being loaded
   always_comb begin
      wr_val           = wr_word;
      wr_val[FIFO_BIT] = wr_dma;
   end

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[g] <= RESET_WORD;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            mem[g] <= wr_val;
         end
      end

      // R9: an entry changes only when it is the one addressed
      assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(mem[g]));
   end

   assign rd_word_a  = mem[rd_idx_a];
   assign rd_flags_b = mem[rd_idx_b][FLAG_LSB +: FLAG_W];

   // R10: stored FIFO enable equals the load kind
   assert_fifo_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_idx)][FIFO_BIT] == $past(wr_dma)));

endmodule

// File: rtl/ata_tm_decode.sv
module ata_tm_decode
   import ata_strobe_pkg::*;
(
   input  logic [TW_W-1:0] word,
   input  logic            reg_kind,
   output phase_tm_t       tm
);

   always_comb begin
      if (reg_kind) begin
         tm.setup  = word[R_SET_LSB +: SET_W];
         tm.active = word[R_ACT_LSB +: ACT_W];
         tm.recov  = word[R_REC_LSB +: REC_W];
      end else begin
         tm.setup  = word[D_SET_LSB +: SET_W];
         tm.active = word[D_ACT_LSB +: ACT_W];
         tm.recov  = word[D_REC_LSB +: REC_W];
      end
   end

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
   import ata_strobe_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      start_wr,
   input  phase_tm_t start_tm,
   output logic      rd_n,
   output logic      wr_n,
   output logic      busy,
   output logic      done
);

   localparam int CNT_W = ACT_W;

   if (CNT_W < SET_W || CNT_W < REC_W) begin : g_bad_cnt
      $error("ata_phase_seq: active field must be the widest");
   end

   phase_e          st_q;
   logic [CNT_W-1:0] cnt_q;
   phase_tm_t       cur_tm_q, pend_tm_q, chain_tm;
   logic            cur_wr_q, pend_wr_q, pend_q, done_q;
   logic            cnt_zero, chain_now, chain_wr;

   assign cnt_zero  = (cnt_q == '0);
   assign chain_now = pend_q || start;
   assign chain_tm  = pend_q ? pend_tm_q : start_tm;
   assign chain_wr  = pend_q ? pend_wr_q : start_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PH_IDLE;
         cnt_q     <= '0;
         cur_tm_q  <= '0;
         pend_tm_q <= '0;
         cur_wr_q  <= 1'b0;
         pend_wr_q <= 1'b0;
         pend_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            PH_IDLE: begin
               if (start) begin
                  st_q     <= PH_SETUP;
                  cnt_q    <= CNT_W'(start_tm.setup);
                  cur_tm_q <= start_tm;
                  cur_wr_q <= start_wr;
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  st_q  <= PH_ACTIVE;
                  cnt_q <= CNT_W'(cur_tm_q.active);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_ACTIVE: begin
               if (cnt_zero) begin
                  st_q  <= PH_RECOV;
                  cnt_q <= CNT_W'(cur_tm_q.recov);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_RECOV: begin
               if (cnt_zero) begin
                  done_q <= 1'b1;
                  pend_q <= 1'b0;
                  if (chain_now) begin
                     st_q     <= PH_ACTIVE;
                     cnt_q    <= CNT_W'(chain_tm.active);
                     cur_tm_q <= chain_tm;
                     cur_wr_q <= chain_wr;
                  end else begin
                     st_q <= PH_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
                  if (start && !pend_q) begin
                     pend_q    <= 1'b1;
                     pend_tm_q <= start_tm;
                     pend_wr_q <= start_wr;
                  end
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   assign rd_n = !((st_q == PH_ACTIVE) && !cur_wr_q);
   assign wr_n = !((st_q == PH_ACTIVE) &&  cur_wr_q);
   assign busy = (st_q != PH_IDLE);
   assign done = done_q;

   // R5: done never lasts two cycles
   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: done only follows a recovery phase
   assert_done_after_recov_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st_q) == PH_RECOV));
   // R6: setup only ever leads into an active phase
   assert_setup_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_SETUP) |=> (st_q == PH_SETUP || st_q == PH_ACTIVE));
   // R4: a strobe is always released before the other may fall
   assert_rd_then_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |=> wr_n);
   assert_wr_then_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> rd_n);
   // R8: captured timing does not move during an active phase
   assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_ACTIVE && $past(st_q) == PH_ACTIVE) |-> $stable(cur_tm_q));

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
   import ata_strobe_pkg::*;
#(
   parameter int          NUM_CH     = 2,
   parameter int          DEV_PER_CH = 2,
   parameter logic [31:0] RESET_WORD = 32'h0,
   localparam int         NUM_DEV    = NUM_CH * DEV_PER_CH,
   localparam int         IDX_W      = $clog2(NUM_DEV),
   localparam int         CH_W       = $clog2(NUM_CH),
   localparam int         DEV_W      = $clog2(DEV_PER_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [TW_W-1:0]   cfg_word,
   input  logic              cfg_dma,
   output logic [FLAG_W-1:0] cfg_flags,
   input  logic              start,
   input  logic [CH_W-1:0]   ch_sel,
   input  logic [DEV_W-1:0]  dev_sel,
   input  logic              acc_reg,
   input  logic              acc_write,
   output logic              rd_n,
   output logic              wr_n,
   output logic              busy,
   output logic              done
);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("ata_strobe_gen: NUM_CH must be a power of two, at least 2");
   end
   if (DEV_PER_CH < 2 || (DEV_PER_CH & (DEV_PER_CH - 1)) != 0) begin : g_bad_dev
      $error("ata_strobe_gen: DEV_PER_CH must be a power of two, at least 2");
   end

   logic [IDX_W-1:0] acc_idx;
   logic [TW_W-1:0]  acc_word;
   phase_tm_t        acc_tm;

   // R9: word index = device + DEV_PER_CH * channel
   assign acc_idx = IDX_W'(dev_sel) + IDX_W'(ch_sel) * IDX_W'(DEV_PER_CH);

   ata_tw_bank #(
      .NUM_WORDS (NUM_DEV),
      .IDX_W     (IDX_W),
      .RESET_WORD(RESET_WORD)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_idx    (cfg_idx),
      .wr_word   (cfg_word),
      .wr_dma    (cfg_dma),
      .rd_idx_a  (acc_idx),
      .rd_word_a (acc_word),
      .rd_idx_b  (cfg_idx),
      .rd_flags_b(cfg_flags)
   );

   ata_tm_decode u_dec (
      .word    (acc_word),
      .reg_kind(acc_reg),
      .tm      (acc_tm)
   );

   ata_phase_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .start_wr(acc_write),
      .start_tm(acc_tm),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .busy    (busy),
      .done    (done)
   );

   // R4: strobes idle high whenever the channel is idle
   assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (!busy -> (rd_n && wr_n)));

endmodule

// File: tb/ata_strobe_gen_tb_top.sv
module ata_strobe_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_word = '0;
   logic        cfg_dma = 1'b0;
   logic [3:0]  cfg_flags;
   logic        start = 1'b0;
   logic [0:0]  ch_sel = '0;
   logic [0:0]  dev_sel = '0;
   logic        acc_reg = 1'b0;
   logic        acc_write = 1'b0;
   logic        rd_n, wr_n, busy, done;

   always #10 clk = ~clk;

   ata_strobe_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_dma(cfg_dma),
      .cfg_flags(cfg_flags),
      .start(start), .ch_sel(ch_sel), .dev_sel(dev_sel),
      .acc_reg(acc_reg), .acc_write(acc_write),
      .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
   );

   typedef struct {
      int wr; int lead; int width; int gap; int req;
   } exp_t;

   exp_t        expq[$];
   logic [31:0] model [4];
   int n_chk = 0, n_fail = 0, n_issued = 0, n_done = 0, overlap = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int ds, input int da, input int dr,
                                      input int rs, input int ra, input int rr,
                                      input logic [3:0] hi);
      return {hi, 3'(rs), 3'(ds), 4'b0000, 5'(ra), 4'(rr), 5'(da), 4'(dr)};
   endfunction

   // ---------------- monitor / scoreboard ----------------
   int   since = 0, wid = 0;
   bit   prev_low = 1'b0;
   exp_t cur;

   always @(negedge clk) begin : mon
      bit lo;
      if (rst_n) begin
         lo = !rd_n || !wr_n;
         if (start && !busy) since = 0;
         else since = since + 1;
         if (prev_low && !lo) since = 1;
         if (!rd_n && !wr_n) overlap++;
         if (!busy && lo) overlap++;
         if (done) begin
            n_done++;
            cur.gap = since;
            if (expq.size() == 0) begin
               chk(1'b0, "R7", "done with nothing expected", 1, 0);
            end else begin
               exp_t e;
               string rq;
               e  = expq.pop_front();
               rq = $sformatf("R%0d", e.req);
               chk(cur.wr == e.wr, rq, "strobe is write", cur.wr, e.wr);
               chk(cur.lead == e.lead, rq, "cycles to strobe fall", cur.lead, e.lead);
               chk(cur.width == e.width, rq, "strobe low cycles", cur.width, e.width);
               chk(cur.gap == e.gap, rq, "cycles release to done", cur.gap, e.gap);
            end
         end
         if (!prev_low && lo) begin
            cur.lead = since;
            cur.wr   = !wr_n ? 1 : 0;
            wid      = 0;
         end
         if (lo) wid++;
         if (prev_low && !lo) cur.width = wid;
         prev_low = lo;
      end
   end

   // ---------------- driver ----------------
   task automatic load(input int idx, input logic [31:0] w, input bit dma);
      logic [3:0] ef;
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_word = w; cfg_dma = dma;
      @(posedge clk); #2;
      cfg_we = 1'b0;
      model[idx] = {dma, w[30:0]};
      ef = {dma, w[30:28]};
      @(negedge clk);
      chk(cfg_flags == ef, "R10", "flags after load", int'(cfg_flags), int'(ef));
   endtask

   task automatic issue(input int ch, input int dev, input bit kind, input bit wr,
                        input int lead, input int req);
      logic [31:0] w;
      exp_t e;
      int s, a, r;
      w = model[dev + 2*ch];
      s = kind ? int'(w[27:25]) : int'(w[24:22]);
      a = kind ? int'(w[17:13]) : int'(w[8:4]);
      r = kind ? int'(w[12:9])  : int'(w[3:0]);
      e.wr = wr ? 1 : 0;
      e.lead = (lead < 0) ? s + 2 : lead;
      e.width = a + 1;
      e.gap = r + 2;
      e.req = req;
      expq.push_back(e);
      n_issued++;
      @(posedge clk); #2;
      start = 1'b1; ch_sel = 1'(ch); dev_sel = 1'(dev); acc_reg = kind; acc_write = wr;
      @(posedge clk); #2;
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_release();
      do @(negedge clk); while (rd_n && wr_n);
      do @(negedge clk); while (!(rd_n && wr_n));
   endtask

   function automatic int rec_of(input int idx, input bit kind);
      return kind ? int'(model[idx][12:9]) : int'(model[idx][3:0]);
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_n == 1'b1, "R1", "rd_n after reset", int'(rd_n), 1);
      chk(wr_n == 1'b1, "R1", "wr_n after reset", int'(wr_n), 1);
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
      chk(cfg_flags == 4'h0, "R1", "flags after reset", int'(cfg_flags), 0);

      // R10 loads: PIO clears FIFO bit, DMA sets it
      load(0, mk(2, 3, 1, 1, 2, 4, 4'b1101), 1'b0);
      load(1, mk(0, 5, 2, 3, 0, 0, 4'b0000), 1'b1);
      load(2, mk(4, 1, 3, 2, 6, 1, 4'b0011), 1'b0);
      load(3, mk(1, 0, 0, 0, 1, 2, 4'b0110), 1'b1);

      // R2 / R9 data accesses on each device
      issue(0, 0, 1'b0, 1'b0, -1, 2);
      @(negedge clk);
      chk(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
      wait_idle();
      issue(0, 1, 1'b0, 1'b1, -1, 9); wait_idle();
      issue(1, 0, 1'b0, 1'b0, -1, 9); wait_idle();
      issue(1, 1, 1'b0, 1'b1, -1, 9); wait_idle();

      // R3 register accesses
      issue(0, 0, 1'b1, 1'b1, -1, 3); wait_idle();
      issue(1, 0, 1'b1, 1'b0, -1, 3); wait_idle();
      issue(1, 1, 1'b1, 1'b1, -1, 3); wait_idle();

      // R6 chained burst: no setup between cycles
      issue(0, 1, 1'b0, 1'b1, -1, 6);
      wait_release();
      issue(1, 0, 1'b0, 1'b0, rec_of(1, 1'b0) + 2, 6);
      wait_release();
      issue(1, 1, 1'b1, 1'b1, rec_of(2, 1'b0) + 2, 6);
      wait_idle();

      // R7 start during active is ignored
      issue(0, 0, 1'b0, 1'b0, -1, 7);
      do @(negedge clk); while (rd_n && wr_n);
      @(posedge clk); #2;
      start = 1'b1; ch_sel = 1'b1; dev_sel = 1'b1; acc_write = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      wait_idle();
      chk(expq.size() == 0, "R7", "queue empty after ignored start", expq.size(), 0);
      chk(n_done == n_issued, "R7", "done count", n_done, n_issued);

      // R8 configuration write during a running access
      issue(1, 0, 1'b1, 1'b0, -1, 8);
      load(2, mk(0, 2, 1, 1, 1, 1, 4'b0000), 1'b0);
      wait_idle();
      issue(1, 0, 1'b1, 1'b0, -1, 8); wait_idle();

      // R2 boundary: every timing field at its maximum
      load(3, mk(7, 31, 15, 7, 31, 15, 4'b0000), 1'b1);
      issue(1, 1, 1'b0, 1'b0, -1, 2); wait_idle();
      issue(1, 1, 1'b1, 1'b1, -1, 3); wait_idle();

      chk(overlap == 0, "R4", "samples with both strobes low or strobe low while idle",
          overlap, 0);
      chk(expq.size() == 0, "R5", "all expected done pulses seen", expq.size(), 0);
      chk(n_done == n_issued, "R5", "done pulse count", n_done, n_issued);
      summary();
      $finish;
   end

endmodule